// File: doc/BRIEF.md
# Power Mode State Controller

This block decides which of three operating modes a power-management device is in: OFF, ACTIVE or SLEEP. In OFF it watches a set of wake events. When a qualifying event arrives and its status bit was still clear, it raises a power-on enable pulse of fixed length. It enters ACTIVE when that pulse ends. At that moment it also captures the boot-pin code as a sequence ID for an external power sequencer.

In ACTIVE, the device goes to SLEEP only when three things hold at the same clock edge:
- the sleep pin is at its active level;
- the sleep-enable bit is set;
- no unmasked interrupt is pending.

It returns from SLEEP to ACTIVE when the pin goes inactive or an unmasked interrupt becomes pending. A long button press, thermal shutdown or the device-off bit forces OFF from either running mode.

Every wake or shutdown event is recorded in a sticky status bit. The block drives an active-low interrupt line from the status bits that are not masked. Software clears status bits with a write-one-to-clear strobe. The clock-sync GPIO event is recorded and can end SLEEP, but it never powers the device on.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state code is OFF (0). All status bits are 0, intN is 1, pwrOnPulse is 0, seqId is 0 and devOffBit is 0.
- R2: In OFF, two events start the power-on pulse when their status bit is clear: a falling edge on pwrBtnN (status bit 0) and a rising edge on pwrHold (status bit 1). pwrOnPulse then stays high for PULSE_LEN cycles. The state becomes ACTIVE (1) at the edge where the pulse drops.
- R3: In OFF, an event whose status bit is already set gives no pulse, and the state stays OFF.
- R4: The following events set a status bit but start a pulse in OFF only when their enable is 1:
  - an RTC alarm pulse (bit 2) or RTC periodic pulse (bit 3), enabled by rtcWakeEn;
  - a supplyHiEv pulse while supplyChgOk is 1 (bit 4), enabled by supplyWakeEn.
  
  A supplyHiEv pulse while supplyChgOk is 0 has no effect.
- R5: A gpioSyncEv pulse sets status bit 5 and never starts a pulse in OFF, whatever the mask. When that bit is unmasked, it ends SLEEP.
- R6: In ACTIVE or SLEEP, pwrBtnN low for LP_DELAY consecutive edges moves the state to OFF at the last of those edges and sets status bit 6. With lpDisable at 1, a press of any length has no effect on the state.
- R7: thermShdn at an edge puts the state in OFF at that edge. In OFF it also cancels a running pulse and blocks a new one.
- R8: devOffWr sets devOffBit. From ACTIVE or SLEEP, the state becomes OFF one edge after the bit is seen. The bit is cleared one edge after that, while in OFF.
- R9: ACTIVE moves to SLEEP (2) at an edge only when all three hold:
  - sleepPin is at its active level (low when sleepPolInv is 0, high when it is 1);
  - sleepEnBit is 1;
  - intN is 1.
- R10: SLEEP returns to ACTIVE at the first edge where sleepPin is inactive or an unmasked status bit is set.
- R11: On leaving OFF, seqId captures the boot pins: 00 gives 0, 10 gives 1, 01 gives 2 and 11 gives 0. seqId holds this value until the next exit from OFF.
- R12: intN is low exactly when some status bit has its intMask bit at 0. A 1 on intClr clears that status bit at the next edge. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrBtnN | input | 1 | Power button, low when pressed |
| pwrHold | input | 1 | Power-hold pin, rising edge wakes |
| sleepPin | input | 1 | Sleep request pin, level sensitive |
| sleepPolInv | input | 1 | 1 makes sleepPin active high |
| sleepEnBit | input | 1 | Sleep-enable control bit |
| rtcAlarmEv | input | 1 | One-cycle RTC alarm event |
| rtcPeriodEv | input | 1 | One-cycle RTC periodic event |
| rtcWakeEn | input | 1 | Lets RTC events power on from OFF |
| supplyHiEv | input | 1 | One-cycle event, first supply rise above the high threshold |
| supplyChgOk | input | 1 | Supply above the charge threshold |
| supplyWakeEn | input | 1 | Lets the supply event power on from OFF |
| gpioSyncEv | input | 1 | One-cycle clock-sync GPIO event |
| thermShdn | input | 1 | Thermal shutdown flag |
| devOffWr | input | 1 | Write strobe setting the device-off bit |
| lpDisable | input | 1 | Disables the long-press shutdown |
| intMask | input | 7 | Per-bit interrupt mask, 1 masks |
| intClr | input | 7 | Write-one-to-clear strobe for the status bits |
| bootPins | input | 2 | Boot-pin code |
| stateCode | output | 2 | OFF=0, ACTIVE=1, SLEEP=2 |
| pwrOnPulse | output | 1 | Power-on enable pulse |
| seqId | output | 2 | Latched power sequence ID |
| statusBits | output | 7 | Sticky interrupt status bits |
| intN | output | 1 | Active-low interrupt line |
| devOffBit | output | 1 | Device-off control bit |

## Verification
The assertions assume that the RTC, supply and GPIO events are single-cycle pulses and that pwrBtnN and pwrHold are already synchronous. They also assume thermShdn is not asserted in the same cycle as a running pulse's last count. The bench keeps to these assumptions:
- it drives every input once per cycle, away from the active edge;
- it raises each event for exactly one cycle;
- it releases the button well before the long-press count whenever it intends only a wake.

The sweeps cover every boot code, every mask value against two fixed status patterns, and all eight combinations of sleep polarity, pin and enable.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SLEEP  = 2'd2
  } pwrState_e;

  localparam int IRQ_N      = 7;
  localparam int IRQ_BTN    = 0;
  localparam int IRQ_HOLD   = 1;
  localparam int IRQ_ALARM  = 2;
  localparam int IRQ_PERIOD = 3;
  localparam int IRQ_SUPPLY = 4;
  localparam int IRQ_GPIO   = 5;
  localparam int IRQ_LP     = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic startPulse;
    logic cancelPulse;
    logic latchSeq;
    logic inOff;
    logic lpArm;
  } ctrlStrobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic wakeReq;
    logic pulseBusy;
    logic pulseLast;
    logic lpHit;
    logic pending;
    logic sleepLevel;
    logic devOffSet;
  } dpInfo_t;

  function automatic logic [1:0] seqMap(input logic [1:0] pins);
    case (pins)
      2'b10:   seqMap = 2'd1;
      2'b01:   seqMap = 2'd2;
      default: seqMap = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwrmode_pkg::*;
#(
  parameter int PULSE_LEN = 4,
  parameter int LP_DELAY  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrBtnN,
  input  logic             pwrHold,
  input  logic             sleepPin,
  input  logic             sleepPolInv,
  input  logic             rtcAlarmEv,
  input  logic             rtcPeriodEv,
  input  logic             rtcWakeEn,
  input  logic             supplyHiEv,
  input  logic             supplyChgOk,
  input  logic             supplyWakeEn,
  input  logic             gpioSyncEv,
  input  logic             devOffWr,
  input  logic             lpDisable,
  input  logic [IRQ_N-1:0] intMask,
  input  logic [IRQ_N-1:0] intClr,
  input  logic [1:0]       bootPins,
  input  ctrlStrobe_t      strobe,
  output dpInfo_t          info,
  output logic [IRQ_N-1:0] statusQ,
  output logic             devOffQ,
  output logic [1:0]       seqIdQ,
  output logic             pwrOnPulse,
  output logic             intN
);

  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam int LW = $clog2(LP_DELAY + 1);

  logic          btnPrev, holdPrev;
  logic          btnFall, holdRise, lpHit, pending;
  logic [IRQ_N-1:0] setVec, wakeAllow;
  logic [PW-1:0] pulseCnt;
  logic [LW-1:0] lpCnt;

  // Edge detection on the two pin-level sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnPrev  <= 1'b1;
      holdPrev <= 1'b0;
    end else begin
      btnPrev  <= pwrBtnN;
      holdPrev <= pwrHold;
    end
  end

  assign btnFall  = btnPrev & ~pwrBtnN;
  assign holdRise = ~holdPrev & pwrHold;

  // Long-press counter: consecutive low samples while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lpCnt <= '0;
    else if (!strobe.lpArm || pwrBtnN) lpCnt <= '0;
    else if (lpCnt != LW'(LP_DELAY)) lpCnt <= lpCnt + 1'b1;
  end

  assign lpHit = strobe.lpArm && !pwrBtnN && !lpDisable
                 && (lpCnt == LW'(LP_DELAY - 1));

  always_comb begin
    setVec             = '0;
    setVec[IRQ_BTN]    = btnFall;
    setVec[IRQ_HOLD]   = holdRise;
    setVec[IRQ_ALARM]  = rtcAlarmEv;
    setVec[IRQ_PERIOD] = rtcPeriodEv;
    setVec[IRQ_SUPPLY] = supplyHiEv & supplyChgOk;
    setVec[IRQ_GPIO]   = gpioSyncEv;
    setVec[IRQ_LP]     = lpHit;

    wakeAllow             = '0;
    wakeAllow[IRQ_BTN]    = 1'b1;
    wakeAllow[IRQ_HOLD]   = 1'b1;
    wakeAllow[IRQ_ALARM]  = rtcWakeEn;
    wakeAllow[IRQ_PERIOD] = rtcWakeEn;
    wakeAllow[IRQ_SUPPLY] = supplyWakeEn;
  end

  // Sticky status with write-one-to-clear; a set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~intClr) | setVec;
  end

  assign pending = |(statusQ & ~intMask);
  assign intN    = ~pending;

  // Power-on enable pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pulseCnt <= '0;
    else if (strobe.cancelPulse) pulseCnt <= '0;
    else if (strobe.startPulse)  pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0)     pulseCnt <= pulseCnt - 1'b1;
  end

  assign pwrOnPulse = (pulseCnt != '0);

  // Device-off control bit, self-clearing in OFF
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             devOffQ <= 1'b0;
    else if (strobe.inOff) devOffQ <= 1'b0;
    else if (devOffWr)     devOffQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                seqIdQ <= 2'd0;
    else if (strobe.latchSeq) seqIdQ <= seqMap(bootPins);
  end

  always_comb begin
    info.wakeReq    = |(setVec & ~statusQ & wakeAllow);
    info.pulseBusy  = pwrOnPulse;
    info.pulseLast  = (pulseCnt == PW'(1));
    info.lpHit      = lpHit;
    info.pending    = pending;
    info.sleepLevel = sleepPolInv ? sleepPin : ~sleepPin;
    info.devOffSet  = devOffQ;
  end

  // R12
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~statusQ & ~$past(intClr)) == '0));

  // R11
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(seqIdQ) |-> $past(strobe.latchSeq));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwrmode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        thermShdn,
  input  logic        sleepEnBit,
  input  dpInfo_t     info,
  output ctrlStrobe_t strobe,
  output pwrState_e   stateQ
);

  pwrState_e stateNxt;
  logic      offReq;

  assign offReq = thermShdn | info.lpHit | info.devOffSet;

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    strobe.inOff = (stateQ == ST_OFF);
    strobe.lpArm = (stateQ != ST_OFF);
    case (stateQ)
      ST_OFF: begin
        if (thermShdn) begin
          strobe.cancelPulse = 1'b1;
        end else if (info.pulseBusy) begin
          if (info.pulseLast) begin
            stateNxt        = ST_ACTIVE;
            strobe.latchSeq = 1'b1;
          end
        end else if (info.wakeReq) begin
          strobe.startPulse = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (offReq) stateNxt = ST_OFF;
        else if (info.sleepLevel && sleepEnBit && !info.pending) stateNxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (offReq) stateNxt = ST_OFF;
        else if (!info.sleepLevel || info.pending) stateNxt = ST_ACTIVE;
      end
      default: stateNxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateNxt;
  end

  // R2
  pulse_before_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && $past(stateQ) == ST_OFF) |-> $past(info.pulseLast));

  // R7
  therm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    thermShdn |=> (stateQ == ST_OFF));

  // R9
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && $past(stateQ) != ST_SLEEP) |->
      ($past(stateQ) == ST_ACTIVE && $past(sleepEnBit)
       && $past(info.sleepLevel) && !$past(info.pending)));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int PULSE_LEN = 4,
  parameter int LP_DELAY  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrBtnN,
  input  logic       pwrHold,
  input  logic       sleepPin,
  input  logic       sleepPolInv,
  input  logic       sleepEnBit,
  input  logic       rtcAlarmEv,
  input  logic       rtcPeriodEv,
  input  logic       rtcWakeEn,
  input  logic       supplyHiEv,
  input  logic       supplyChgOk,
  input  logic       supplyWakeEn,
  input  logic       gpioSyncEv,
  input  logic       thermShdn,
  input  logic       devOffWr,
  input  logic       lpDisable,
  input  logic [6:0] intMask,
  input  logic [6:0] intClr,
  input  logic [1:0] bootPins,
  output logic [1:0] stateCode,
  output logic       pwrOnPulse,
  output logic [1:0] seqId,
  output logic [6:0] statusBits,
  output logic       intN,
  output logic       devOffBit
);

  ctrlStrobe_t strobe;
  dpInfo_t     info;
  pwrState_e   stateQ;

  pwr_mode_dp #(.PULSE_LEN(PULSE_LEN), .LP_DELAY(LP_DELAY)) dpInst (
    .clk(clk), .rstN(rstN), .pwrBtnN(pwrBtnN), .pwrHold(pwrHold),
    .sleepPin(sleepPin), .sleepPolInv(sleepPolInv),
    .rtcAlarmEv(rtcAlarmEv), .rtcPeriodEv(rtcPeriodEv), .rtcWakeEn(rtcWakeEn),
    .supplyHiEv(supplyHiEv), .supplyChgOk(supplyChgOk), .supplyWakeEn(supplyWakeEn),
    .gpioSyncEv(gpioSyncEv), .devOffWr(devOffWr), .lpDisable(lpDisable),
    .intMask(intMask), .intClr(intClr), .bootPins(bootPins),
    .strobe(strobe), .info(info), .statusQ(statusBits), .devOffQ(devOffBit),
    .seqIdQ(seqId), .pwrOnPulse(pwrOnPulse), .intN(intN)
  );

  pwr_mode_fsm fsmInst (
    .clk(clk), .rstN(rstN), .thermShdn(thermShdn), .sleepEnBit(sleepEnBit),
    .info(info), .strobe(strobe), .stateQ(stateQ)
  );

  assign stateCode = stateQ;

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

  localparam int PULSE = 4;
  localparam int LPD   = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic pwrBtnN = 1'b1, pwrHold = 1'b0, sleepPin = 1'b1, sleepPolInv = 1'b0;
  logic sleepEnBit = 1'b0, rtcAlarmEv = 1'b0, rtcPeriodEv = 1'b0, rtcWakeEn = 1'b0;
  logic supplyHiEv = 1'b0, supplyChgOk = 1'b0, supplyWakeEn = 1'b0, gpioSyncEv = 1'b0;
  logic thermShdn = 1'b0, devOffWr = 1'b0, lpDisable = 1'b0;
  logic [6:0] intMask = '0, intClr = '0;
  logic [1:0] bootPins = 2'b00;
  logic [1:0] stateCode, seqId;
  logic pwrOnPulse, intN, devOffBit;
  logic [6:0] statusBits;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.PULSE_LEN(PULSE), .LP_DELAY(LPD)) uut (
    .clk(clk), .rstN(rstN), .pwrBtnN(pwrBtnN), .pwrHold(pwrHold),
    .sleepPin(sleepPin), .sleepPolInv(sleepPolInv), .sleepEnBit(sleepEnBit),
    .rtcAlarmEv(rtcAlarmEv), .rtcPeriodEv(rtcPeriodEv), .rtcWakeEn(rtcWakeEn),
    .supplyHiEv(supplyHiEv), .supplyChgOk(supplyChgOk), .supplyWakeEn(supplyWakeEn),
    .gpioSyncEv(gpioSyncEv), .thermShdn(thermShdn), .devOffWr(devOffWr),
    .lpDisable(lpDisable), .intMask(intMask), .intClr(intClr), .bootPins(bootPins),
    .stateCode(stateCode), .pwrOnPulse(pwrOnPulse), .seqId(seqId),
    .statusBits(statusBits), .intN(intN), .devOffBit(devOffBit)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input int act, input int exp, input string tag);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clearStatus();
    intClr = '1; step(1); intClr = '0;
  endtask

  task automatic powerOnBtn();
    pwrBtnN = 1'b0; step(1); pwrBtnN = 1'b1;
    step(PULSE);
  endtask

  task automatic goOffDev();
    devOffWr = 1'b1; step(1); devOffWr = 1'b0;
    step(2);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulseCycles;
    step(2);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chkEq(stateCode, 0, "R1 state");
    chkEq(statusBits, 0, "R1 status");
    chkEq(intN, 1, "R1 intN");
    chkEq(pwrOnPulse, 0, "R1 pulse");
    chkEq(seqId, 0, "R1 seqId");
    chkEq(devOffBit, 0, "R1 devOff");

    // R2 button wake: measure pulse width
    pwrBtnN = 1'b0; step(1); pwrBtnN = 1'b1;
    pulseCycles = 0;
    while (pwrOnPulse && pulseCycles < 20) begin
      chkEq(stateCode, 0, "R2 off during pulse");
      pulseCycles++;
      step(1);
    end
    chkEq(pulseCycles, PULSE, "R2 pulse width");
    chkEq(stateCode, 1, "R2 active after pulse");
    chkEq(statusBits[0], 1, "R2 btn status");

    // R8 device-off bit
    devOffWr = 1'b1; step(1); devOffWr = 1'b0;
    chkEq(devOffBit, 1, "R8 bit set");
    chkEq(stateCode, 1, "R8 still active");
    step(1);
    chkEq(stateCode, 0, "R8 off");
    step(1);
    chkEq(devOffBit, 0, "R8 cleared");

    // R3 pending status blocks power-on
    pwrBtnN = 1'b0; step(1); pwrBtnN = 1'b1;
    chkEq(pwrOnPulse, 0, "R3 no pulse");
    step(PULSE + 2);
    chkEq(stateCode, 0, "R3 stays off");
    clearStatus();
    chkEq(statusBits, 0, "R12 w1c all");

    // R2 hold rising edge wake
    pwrHold = 1'b1; step(1);
    chkEq(pwrOnPulse, 1, "R2 hold pulse");
    chkEq(statusBits[1], 1, "R2 hold status");
    step(PULSE);
    chkEq(stateCode, 1, "R2 hold active");
    pwrHold = 1'b0;
    goOffDev(); clearStatus();

    // R4 optional wake sources, swept over source and enable
    for (int src = 0; src < 4; src++) begin
      for (int en = 0; en < 2; en++) begin
        rtcWakeEn = en[0]; supplyWakeEn = en[0];
        supplyChgOk = (src != 3);
        case (src)
          0: rtcAlarmEv = 1'b1;
          1: rtcPeriodEv = 1'b1;
          default: supplyHiEv = 1'b1;
        endcase
        step(1);
        rtcAlarmEv = 1'b0; rtcPeriodEv = 1'b0; supplyHiEv = 1'b0;
        if (src == 3) begin
          chkEq(statusBits, 0, "R4 supply no charge status");
          chkEq(pwrOnPulse, 0, "R4 supply no charge pulse");
        end else begin
          chkEq(statusBits[2 + (src == 2 ? 2 : src)], 1, "R4 status set");
          chkEq(pwrOnPulse, en, "R4 pulse by enable");
          if (en == 1) begin
            step(PULSE);
            chkEq(stateCode, 1, "R4 active");
            goOffDev();
          end
        end
        clearStatus();
      end
    end
    rtcWakeEn = 1'b0; supplyWakeEn = 1'b0;

    // R5 gpio never wakes from OFF
    gpioSyncEv = 1'b1; step(1); gpioSyncEv = 1'b0;
    chkEq(pwrOnPulse, 0, "R5 no pulse");
    chkEq(statusBits[5], 1, "R5 status");
    step(PULSE + 1);
    chkEq(stateCode, 0, "R5 stays off");

    // R12 exhaustive mask sweep, status = bit5
    for (int m = 0; m < 128; m++) begin
      intMask = 7'(m); #1;
      chkEq(intN, m[5], "R12 intN single");
    end
    rtcAlarmEv = 1'b1; step(1); rtcAlarmEv = 1'b0;
    for (int m = 0; m < 128; m++) begin
      intMask = 7'(m); #1;
      chkEq(intN, m[5] & m[2], "R12 intN pair");
    end
    intMask = '0;
    intClr = 7'b0000100; step(1); intClr = '0;
    chkEq(statusBits, 7'b0100000, "R12 w1c single");
    gpioSyncEv = 1'b1; intClr = 7'b0100000; step(1);
    gpioSyncEv = 1'b0; intClr = '0;
    chkEq(statusBits[5], 1, "R12 set wins");
    clearStatus();

    // R7 thermal blocks and cancels in OFF
    thermShdn = 1'b1;
    pwrBtnN = 1'b0; step(1); pwrBtnN = 1'b1;
    chkEq(pwrOnPulse, 0, "R7 blocked");
    thermShdn = 1'b0; clearStatus();
    pwrBtnN = 1'b0; step(1); pwrBtnN = 1'b1;
    chkEq(pwrOnPulse, 1, "R7 pulse started");
    thermShdn = 1'b1; step(1);
    chkEq(pwrOnPulse, 0, "R7 pulse cancelled");
    thermShdn = 1'b0; step(PULSE + 1);
    chkEq(stateCode, 0, "R7 still off");
    clearStatus();

    // R11 boot code sweep
    for (int b = 0; b < 4; b++) begin
      bootPins = 2'(b);
      powerOnBtn();
      chkEq(stateCode, 1, "R11 active");
      chkEq(seqId, (b == 2) ? 1 : (b == 1) ? 2 : 0, "R11 seq map");
      bootPins = ~2'(b); step(2);
      chkEq(seqId, (b == 2) ? 1 : (b == 1) ? 2 : 0, "R11 seq held");
      goOffDev(); clearStatus();
    end

    // R7 thermal from ACTIVE
    powerOnBtn(); clearStatus();
    thermShdn = 1'b1; step(1); thermShdn = 1'b0;
    chkEq(stateCode, 0, "R7 active to off");
    clearStatus();

    // R9/R10 sleep sweep over polarity, pin, enable
    powerOnBtn(); clearStatus();
    for (int pol = 0; pol < 2; pol++) begin
      for (int pin = 0; pin < 2; pin++) begin
        for (int en = 0; en < 2; en++) begin
          sleepPolInv = pol[0]; sleepPin = ~pol[0]; sleepEnBit = 1'b0; step(1);
          sleepPin = pin[0]; sleepEnBit = en[0]; step(1);
          chkEq(stateCode, ((pin == pol) && en == 1) ? 2 : 1, "R9 sleep entry");
          sleepPin = ~pol[0]; step(1);
          chkEq(stateCode, 1, "R10 pin exit");
        end
      end
    end
    sleepPolInv = 1'b0; sleepPin = 1'b1; sleepEnBit = 1'b0; step(1);

    // R9 pending blocks entry; R5/R10 gpio wakes from SLEEP
    gpioSyncEv = 1'b1; step(1); gpioSyncEv = 1'b0;
    sleepPin = 1'b0; sleepEnBit = 1'b1; step(2);
    chkEq(stateCode, 1, "R9 pending blocks");
    intMask = 7'b0100000; step(1);
    chkEq(stateCode, 2, "R9 masked enters");
    intMask = '0; step(1);
    chkEq(stateCode, 1, "R5 gpio sleep wake");
    clearStatus(); step(1);
    chkEq(stateCode, 2, "R10 back to sleep");

    // R6 long press from SLEEP
    intMask = 7'b0000001;
    pwrBtnN = 1'b0; step(LPD - 1);
    chkEq(stateCode, 2, "R6 before delay");
    step(1);
    chkEq(stateCode, 0, "R6 long press off");
    chkEq(statusBits[6], 1, "R6 lp status");
    pwrBtnN = 1'b1; sleepPin = 1'b1; sleepEnBit = 1'b0; intMask = '0;
    step(1); clearStatus();

    // R6 disabled
    powerOnBtn(); clearStatus();
    lpDisable = 1'b1; intMask = 7'b0000001;
    pwrBtnN = 1'b0; step(LPD + 4);
    chkEq(stateCode, 1, "R6 disabled stays");
    chkEq(statusBits[6], 0, "R6 disabled no status");
    pwrBtnN = 1'b1; lpDisable = 1'b0; step(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule